// File: doc/BRIEF.md
# Two-Wire Master Host Register Front-End

This block is the host-side register file and interrupt combiner that sits in front of a bit-level two-wire (I2C) master sequencer. Software sees a small register window through a simple strobe interface. It contains the following:

- a clock divider;
- a control/status word with interrupt enables and event flags;
- an address/control word that launches transfers;
- a transfer length;
- the data and status ports of two byte FIFOs, one for transmit and one for receive.

The sequencer receives the divider, the length, the address byte and the no-STOP option. It gets a one-cycle start pulse and a one-cycle soft-reset pulse. It reports completion, address NACK and data NACK as single-cycle pulses. It pops bytes from the transmit FIFO and pushes bytes into the receive FIFO.

Transfers may be longer than a FIFO. Each FIFO has a service request, gated by its own enable. Software sets that enable and services the request while a transfer runs: it refills the transmit FIFO while it has room and drains the receive FIFO while it holds data. All enabled events and both service requests drive one interrupt line.

Top module: `twi_host_regs`

## Requirements
- R1: After reset every readable register returns 0, both FIFOs are empty, and `irq`, `seq_start` and `seq_soft_reset` are low.
- R2: The divider (byte offset 0) and the length (offset 6) are 16-bit read/write registers. Bits 7:0 (address byte, read flag in bit 0) and bit 9 (no-STOP) of the address/control word (offset 4) are stored, read back, and driven on `seq_addr_rw` and `seq_nostop`. Bits 8 and 13 of that word read as 0.
- R3: Writing offset 4 with bit 8 set and bit 13 clear raises `seq_start` for exactly one cycle, starting in the cycle after the write. The same write clears all three event flags.
- R4: In the control/status word (offset 2), bits 2:0 are read/write enables. Bits 10:8 are the completion, address-NACK and data-NACK flags. A flag is set by its `seq_done`, `seq_anack` or `seq_dnack` pulse and ignores host writes. It stays set until a start or a soft reset.
- R5: `irq` is high when any flag is set together with its enable bit (flag bit n+8 with enable bit n), or when either FIFO service request is active.
- R6: Bit 11 of the control/status word is the transmit service request: the transmit enable is set and that FIFO holds fewer than 16 bytes. Bit 12 is the receive service request: the receive enable is set and that FIFO holds at least one byte. The transmit status word is at offset 24 and the receive status word at offset 40. In each, bit 15 is the read/write service enable.
- R7: Each FIFO holds 16 bytes in first-in first-out order. Bits 5:0 of its status word read the current fill count. Host writes to offset 16 push the low byte into the transmit FIFO. Host reads of offset 32 pop the receive FIFO.
- R8: A push into a full FIFO is ignored and the count stays 16. A pop from an empty FIFO is ignored, returns 0 and leaves the count at 0.
- R9: Writing 1 to bit 14 of a FIFO status word empties that FIFO. Bit 14 reads as 0, and bit 15 takes the written value.
- R10: Writing offset 4 with bit 13 set raises `seq_soft_reset` for one cycle from the next cycle. It empties both FIFOs, clears all event flags, and does not start a transfer, even if bit 8 is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (pops the receive port) |
| host_addr | input | ADDR_W (6) | Byte offset of the register |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data for `host_addr`, valid in the cycle of the strobe |
| irq | output | 1 | Combined interrupt |
| seq_start | output | 1 | One-cycle transfer start |
| seq_soft_reset | output | 1 | One-cycle sequencer reset |
| seq_clkdiv | output | 16 | Divider value |
| seq_addr_rw | output | 8 | Target address shifted left by one, read flag in bit 0 |
| seq_nostop | output | 1 | Omit STOP at the end of the transfer |
| seq_length | output | 16 | Transfer length in bytes |
| seq_done | input | 1 | Completion pulse |
| seq_anack | input | 1 | Address not acknowledged pulse |
| seq_dnack | input | 1 | Data not acknowledged pulse |
| seq_tx_pop | input | 1 | Sequencer takes a transmit byte |
| seq_tx_data | output | 8 | Head of transmit FIFO (0 when empty) |
| seq_tx_empty | output | 1 | Transmit FIFO empty |
| seq_rx_push | input | 1 | Sequencer stores a received byte |
| seq_rx_data | input | 8 | Received byte |
| seq_rx_full | output | 1 | Receive FIFO full |

## Verification
The assertions assume that the sequencer event inputs are single-cycle pulses sampled only after reset. They also assume that a host strobe carries one address at a time: never a read and a write to the same FIFO port in one cycle. The bench drives each strobe alone, from tasks that keep it for exactly one clock. Its random phase picks one operation per step, so a FIFO is never pushed and popped in the same cycle. Overflow and underflow are still reached on purpose, by pushing past 16 bytes and by popping at zero.

// File: rtl/twi_regs_pkg.sv
package twi_regs_pkg;
   localparam int REG_W       = 16;
   localparam int OFS_CLKDIV  = 0;
   localparam int OFS_CTRL    = 2;
   localparam int OFS_ADDR    = 4;
   localparam int OFS_LEN     = 6;
   localparam int OFS_TXDATA  = 16;
   localparam int OFS_TXSTAT  = 24;
   localparam int OFS_RXDATA  = 32;
   localparam int OFS_RXSTAT  = 40;
   localparam int EVT_N       = 3;
   localparam int FLAG_LSB    = 8;
   localparam int BIT_TXSVC   = 11;
   localparam int BIT_RXSVC   = 12;
   localparam int BIT_GO      = 8;
   localparam int BIT_NOSTOP  = 9;
   localparam int BIT_SRST    = 13;
   localparam int BIT_FLUSH   = 14;
   localparam int BIT_SVC_EN  = 15;
   localparam int CNT_FIELD_W = 6;
endpackage

// File: rtl/twi_byte_fifo.sv
module twi_byte_fifo #(
   parameter int DEPTH = 16,
   parameter int DW    = 8,
   localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush_i,
   input  logic          push_i,
   input  logic [DW-1:0] wdata_i,
   input  logic          pop_i,
   output logic [DW-1:0] rdata_o,
   output logic [CW-1:0] count_o,
   output logic          full_o,
   output logic          empty_o
);
   generate
      if (DEPTH < 2 || DEPTH > 63) begin : g_bad_depth
         $error("twi_byte_fifo: DEPTH must lie in 2..63 to fit the count field");
      end
   endgenerate

   logic [DW-1:0] mem [DEPTH];
   logic [PW-1:0] wp, rp, wp_nx, rp_nx;
   logic [CW-1:0] cnt;
   logic          do_push, do_pop;

   assign full_o  = (cnt == CW'(DEPTH));
   assign empty_o = (cnt == '0);
   assign do_push = push_i && !full_o && !flush_i;
   assign do_pop  = pop_i && !empty_o && !flush_i;
   assign count_o = cnt;
   assign rdata_o = empty_o ? '0 : mem[rp];

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2_wrap
         assign wp_nx = wp + 1'b1;
         assign rp_nx = rp + 1'b1;
      end else begin : g_mod_wrap
         assign wp_nx = (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
         assign rp_nx = (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= wdata_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else if (flush_i) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp_nx;
         if (do_pop)  rp <= rp_nx;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (full_o && push_i && !pop_i && !flush_i) |=> (full_o && $stable(count_o)));

   assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (empty_o && pop_i && !push_i && !flush_i) |=> empty_o);

   assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> empty_o);
endmodule

// File: rtl/twi_event_flags.sv
module twi_event_flags #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic [N-1:0] evt_i,
   input  logic [N-1:0] en_i,
   input  logic [1:0]   svc_i,
   output logic [N-1:0] flags_o,
   output logic         irq_o
);
   generate
      if (N < 1) begin : g_bad_n
         $error("twi_event_flags: N must be at least 1");
      end
      for (genvar i = 0; i < N; i++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        flags_o[i] <= 1'b0;
            else if (clr_i)    flags_o[i] <= 1'b0;
            else if (evt_i[i]) flags_o[i] <= 1'b1;
         end

         assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_o[i] && !clr_i) |=> flags_o[i]);

         assert_flag_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_i[i] && !clr_i) |=> flags_o[i]);
      end
   endgenerate

   assign irq_o = (|(flags_o & en_i)) | (|svc_i);
endmodule

// File: rtl/twi_host_regs.sv
module twi_host_regs
   import twi_regs_pkg::*;
#(
   parameter int ADDR_W     = 6,
   parameter int FIFO_DEPTH = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [REG_W-1:0]  host_wdata,
   output logic [REG_W-1:0]  host_rdata,
   output logic              irq,
   output logic              seq_start,
   output logic              seq_soft_reset,
   output logic [REG_W-1:0]  seq_clkdiv,
   output logic [7:0]        seq_addr_rw,
   output logic              seq_nostop,
   output logic [REG_W-1:0]  seq_length,
   input  logic              seq_done,
   input  logic              seq_anack,
   input  logic              seq_dnack,
   input  logic              seq_tx_pop,
   output logic [7:0]        seq_tx_data,
   output logic              seq_tx_empty,
   input  logic              seq_rx_push,
   input  logic [7:0]        seq_rx_data,
   output logic              seq_rx_full
);
   localparam int CW = $clog2(FIFO_DEPTH + 1);

   generate
      if (ADDR_W < 6) begin : g_bad_addr
         $error("twi_host_regs: ADDR_W must cover byte offset 40");
      end
   endgenerate

   logic wr_div, wr_ctrl, wr_addr, wr_len, wr_txd, wr_txs, wr_rxs, rd_rxd;
   assign wr_div  = host_wr && (host_addr == ADDR_W'(OFS_CLKDIV));
   assign wr_ctrl = host_wr && (host_addr == ADDR_W'(OFS_CTRL));
   assign wr_addr = host_wr && (host_addr == ADDR_W'(OFS_ADDR));
   assign wr_len  = host_wr && (host_addr == ADDR_W'(OFS_LEN));
   assign wr_txd  = host_wr && (host_addr == ADDR_W'(OFS_TXDATA));
   assign wr_txs  = host_wr && (host_addr == ADDR_W'(OFS_TXSTAT));
   assign wr_rxs  = host_wr && (host_addr == ADDR_W'(OFS_RXSTAT));
   assign rd_rxd  = host_rd && (host_addr == ADDR_W'(OFS_RXDATA));

   logic srst_w, go_w;
   assign srst_w = wr_addr && host_wdata[BIT_SRST];
   assign go_w   = wr_addr && host_wdata[BIT_GO] && !host_wdata[BIT_SRST];

   logic [EVT_N-1:0] en_q;
   logic             tx_ie_q, rx_ie_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seq_clkdiv     <= '0;
         seq_length     <= '0;
         seq_addr_rw    <= '0;
         seq_nostop     <= 1'b0;
         en_q           <= '0;
         tx_ie_q        <= 1'b0;
         rx_ie_q        <= 1'b0;
         seq_start      <= 1'b0;
         seq_soft_reset <= 1'b0;
      end else begin
         seq_start      <= go_w;
         seq_soft_reset <= srst_w;
         if (wr_div)  seq_clkdiv <= host_wdata;
         if (wr_len)  seq_length <= host_wdata;
         if (wr_ctrl) en_q       <= host_wdata[EVT_N-1:0];
         if (wr_txs)  tx_ie_q    <= host_wdata[BIT_SVC_EN];
         if (wr_rxs)  rx_ie_q    <= host_wdata[BIT_SVC_EN];
         if (wr_addr) begin
            seq_addr_rw <= host_wdata[7:0];
            seq_nostop  <= host_wdata[BIT_NOSTOP];
         end
      end
   end

   logic [CW-1:0] tx_cnt, rx_cnt;
   logic [7:0]    rx_head;
   logic          tx_full, rx_empty;

   twi_byte_fifo #(.DEPTH(FIFO_DEPTH), .DW(8)) i_tx_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush_i (srst_w || (wr_txs && host_wdata[BIT_FLUSH])),
      .push_i  (wr_txd),
      .wdata_i (host_wdata[7:0]),
      .pop_i   (seq_tx_pop),
      .rdata_o (seq_tx_data),
      .count_o (tx_cnt),
      .full_o  (tx_full),
      .empty_o (seq_tx_empty)
   );

   twi_byte_fifo #(.DEPTH(FIFO_DEPTH), .DW(8)) i_rx_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush_i (srst_w || (wr_rxs && host_wdata[BIT_FLUSH])),
      .push_i  (seq_rx_push),
      .wdata_i (seq_rx_data),
      .pop_i   (rd_rxd),
      .rdata_o (rx_head),
      .count_o (rx_cnt),
      .full_o  (seq_rx_full),
      .empty_o (rx_empty)
   );

   logic [1:0]       svc;
   logic [EVT_N-1:0] flags;
   assign svc[0] = tx_ie_q && !tx_full;
   assign svc[1] = rx_ie_q && !rx_empty;

   twi_event_flags #(.N(EVT_N)) i_events (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (go_w || srst_w),
      .evt_i   ({seq_dnack, seq_anack, seq_done}),
      .en_i    (en_q),
      .svc_i   (svc),
      .flags_o (flags),
      .irq_o   (irq)
   );

   always_comb begin
      host_rdata = '0;
      case (host_addr)
         ADDR_W'(OFS_CLKDIV): host_rdata = seq_clkdiv;
         ADDR_W'(OFS_CTRL): begin
            host_rdata[EVT_N-1:0]                  = en_q;
            host_rdata[FLAG_LSB +: EVT_N]          = flags;
            host_rdata[BIT_TXSVC]                  = svc[0];
            host_rdata[BIT_RXSVC]                  = svc[1];
         end
         ADDR_W'(OFS_ADDR): begin
            host_rdata[7:0]        = seq_addr_rw;
            host_rdata[BIT_NOSTOP] = seq_nostop;
         end
         ADDR_W'(OFS_LEN): host_rdata = seq_length;
         ADDR_W'(OFS_TXSTAT): begin
            host_rdata[CNT_FIELD_W-1:0] = CNT_FIELD_W'(tx_cnt);
            host_rdata[BIT_SVC_EN]      = tx_ie_q;
         end
         ADDR_W'(OFS_RXDATA): host_rdata[7:0] = rx_head;
         ADDR_W'(OFS_RXSTAT): begin
            host_rdata[CNT_FIELD_W-1:0] = CNT_FIELD_W'(rx_cnt);
            host_rdata[BIT_SVC_EN]      = rx_ie_q;
         end
         default: host_rdata = '0;
      endcase
   end

   assert_start_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      go_w |=> (seq_start && flags == '0));

   assert_start_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_start && !$past(go_w)) |-> 1'b0);

   assert_soft_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
      srst_w |=> (seq_soft_reset && !seq_start && seq_tx_empty && tx_cnt == '0
                  && rx_empty && flags == '0));
endmodule

// File: tb/test_twi_host_regs.sv
module test_twi_host_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0, host_rd = 1'b0;
   logic [5:0]  host_addr = '0;
   logic [15:0] host_wdata = '0;
   logic [15:0] host_rdata;
   logic        irq, seq_start, seq_soft_reset, seq_nostop;
   logic [15:0] seq_clkdiv, seq_length;
   logic [7:0]  seq_addr_rw, seq_tx_data;
   logic        seq_done = 1'b0, seq_anack = 1'b0, seq_dnack = 1'b0;
   logic        seq_tx_pop = 1'b0, seq_rx_push = 1'b0;
   logic [7:0]  seq_rx_data = '0;
   logic        seq_tx_empty, seq_rx_full;

   int total = 0;
   int failed = 0;

   always #10 clk = ~clk;

   twi_host_regs i_twi_host_regs (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .irq(irq), .seq_start(seq_start), .seq_soft_reset(seq_soft_reset),
      .seq_clkdiv(seq_clkdiv), .seq_addr_rw(seq_addr_rw), .seq_nostop(seq_nostop),
      .seq_length(seq_length), .seq_done(seq_done), .seq_anack(seq_anack),
      .seq_dnack(seq_dnack), .seq_tx_pop(seq_tx_pop), .seq_tx_data(seq_tx_data),
      .seq_tx_empty(seq_tx_empty), .seq_rx_push(seq_rx_push),
      .seq_rx_data(seq_rx_data), .seq_rx_full(seq_rx_full)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         failed++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [15:0] d);
      @(negedge clk);
      host_addr = a; host_wdata = d; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [15:0] d);
      @(negedge clk);
      host_addr = a; host_rd = 1'b1;
      #1 d = host_rdata;
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   task automatic pulse(input int which);
      @(negedge clk);
      case (which)
         0: seq_done = 1'b1;
         1: seq_anack = 1'b1;
         default: seq_dnack = 1'b1;
      endcase
      @(negedge clk);
      seq_done = 1'b0; seq_anack = 1'b0; seq_dnack = 1'b0;
   endtask

   task automatic tx_take(output logic [7:0] d);
      @(negedge clk);
      d = seq_tx_data; seq_tx_pop = 1'b1;
      @(negedge clk);
      seq_tx_pop = 1'b0;
   endtask

   task automatic rx_give(input logic [7:0] d);
      @(negedge clk);
      seq_rx_data = d; seq_rx_push = 1'b1;
      @(negedge clk);
      seq_rx_push = 1'b0;
   endtask

   function automatic logic [15:0] stat_word(input bit ie, input int cnt);
      return {ie, 9'd0, 6'(cnt)};
   endfunction

   function automatic logic exp_irq(input int txn, input int rxn, input bit txie, input bit rxie);
      return (txie && txn < 16) || (rxie && rxn > 0);
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      failed++; total++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
   end

   initial begin
      logic [15:0] v;
      logic [7:0]  b;
      logic [7:0]  txq[$];
      logic [7:0]  rxq[$];
      void'($urandom(32'd4242));

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      foreach (txq[i]) txq.delete();
      rd(6'd0, v);  chk("R1 divider", v, 16'h0);
      rd(6'd2, v);  chk("R1 ctrl", v, 16'h0);
      rd(6'd4, v);  chk("R1 addr", v, 16'h0);
      rd(6'd24, v); chk("R1 txstat", v, 16'h0);
      rd(6'd40, v); chk("R1 rxstat", v, 16'h0);
      chk("R1 outputs", {irq, seq_start, seq_soft_reset, seq_tx_empty}, 16'h1);

      // R2 configuration registers
      wr(6'd0, 16'h009C); rd(6'd0, v); chk("R2 divider", v, 16'h009C);
      chk("R2 seq_clkdiv", seq_clkdiv, 16'h009C);
      wr(6'd6, 16'h0021); rd(6'd6, v); chk("R2 length", v, 16'h0021);
      chk("R2 seq_length", seq_length, 16'h0021);
      wr(6'd4, 16'h02A5);
      chk("R2 no start", {15'd0, seq_start}, 16'h0);
      rd(6'd4, v); chk("R2 addr word", v, 16'h02A5);
      chk("R2 seq addr", {7'd0, seq_nostop, seq_addr_rw}, 16'h01A5);

      // R4 / R5 event flags and interrupt
      wr(6'd2, 16'h0001);
      pulse(0);
      rd(6'd2, v); chk("R4 done flag", v, 16'h0101);
      chk("R5 irq enabled flag", {15'd0, irq}, 16'h1);
      pulse(1);
      rd(6'd2, v); chk("R4 anack flag", v, 16'h0301);
      wr(6'd2, 16'h0000);
      chk("R5 irq masked", {15'd0, irq}, 16'h0);
      wr(6'd2, 16'h0700);
      rd(6'd2, v); chk("R4 flags not writable", v, 16'h0300);

      // R3 start pulse clears flags
      wr(6'd4, 16'h0150);
      chk("R3 start high", {15'd0, seq_start}, 16'h1);
      @(negedge clk);
      chk("R3 start one cycle", {15'd0, seq_start}, 16'h0);
      rd(6'd2, v); chk("R3 flags cleared", v, 16'h0000);
      rd(6'd4, v); chk("R2 go bit reads 0", v, 16'h0050);

      // R10 soft reset
      wr(6'd2, 16'h0004);
      pulse(2);
      chk("R5 dnack irq", {15'd0, irq}, 16'h1);
      wr(6'd16, 16'h0011); wr(6'd16, 16'h0022);
      rx_give(8'h33);
      wr(6'd4, 16'h2100);
      chk("R10 srst pulse", {14'd0, seq_soft_reset, seq_start}, 16'h2);
      @(negedge clk);
      chk("R10 srst one cycle", {15'd0, seq_soft_reset}, 16'h0);
      rd(6'd2, v);  chk("R10 flags cleared", v, 16'h0004);
      rd(6'd24, v); chk("R10 tx emptied", v, 16'h0000);
      rd(6'd40, v); chk("R10 rx emptied", v, 16'h0000);

      // R6 / R7 / R8 transmit side
      wr(6'd24, 16'h8000);
      rd(6'd2, v); chk("R6 tx svc on empty", v & 16'h1800, 16'h0800);
      chk("R5 irq tx svc", {15'd0, irq}, 16'h1);
      for (int i = 0; i < 17; i++) wr(6'd16, 16'(8'hA0 + i));
      rd(6'd24, v); chk("R8 tx full count", v, 16'h8010);
      rd(6'd2, v); chk("R6 tx svc off when full", v & 16'h1800, 16'h0000);
      chk("R5 irq off", {15'd0, irq}, 16'h0);
      for (int i = 0; i < 3; i++) begin
         tx_take(b); chk("R7 tx order", {8'd0, b}, 16'(8'hA0 + i));
      end
      rd(6'd24, v); chk("R7 tx count", v, 16'h800D);

      // R9 flush keeps enable
      wr(6'd24, 16'hC000);
      rd(6'd24, v); chk("R9 tx flush", v, 16'h8000);
      tx_take(b); chk("R8 empty tx pop zero", {8'd0, b}, 16'h0);

      // receive side
      rx_give(8'h5A); rx_give(8'hC3); rx_give(8'h7E);
      rd(6'd40, v); chk("R7 rx count", v, 16'h0003);
      rd(6'd2, v); chk("R6 rx svc gated", v & 16'h1000, 16'h0000);
      wr(6'd40, 16'h8000);
      rd(6'd2, v); chk("R6 rx svc on", v & 16'h1000, 16'h1000);
      rd(6'd32, v); chk("R7 rx first", v, 16'h005A);
      rd(6'd32, v); chk("R7 rx second", v, 16'h00C3);
      wr(6'd40, 16'h4000);
      rd(6'd40, v); chk("R9 rx flush", v, 16'h0000);
      rd(6'd32, v); chk("R8 empty rx read zero", v, 16'h0000);
      rd(6'd40, v); chk("R8 rx count stays 0", v, 16'h0000);

      // random streaming phase
      wr(6'd2, 16'h0000);
      wr(6'd24, 16'hC000);
      wr(6'd40, 16'hC000);
      for (int n = 0; n < 600; n++) begin
         int op;
         op = $urandom_range(0, 4);
         case (op)
            0: begin
               b = 8'($urandom);
               wr(6'd16, {8'd0, b});
               if (txq.size() < 16) txq.push_back(b);
            end
            1: begin
               tx_take(b);
               if (txq.size() > 0) begin
                  chk("R7 rand tx data", {8'd0, b}, {8'd0, txq[0]});
                  void'(txq.pop_front());
               end else chk("R8 rand tx empty", {8'd0, b}, 16'h0);
            end
            2: begin
               b = 8'($urandom);
               rx_give(b);
               if (rxq.size() < 16) rxq.push_back(b);
            end
            3: begin
               rd(6'd32, v);
               if (rxq.size() > 0) begin
                  chk("R7 rand rx data", v, {8'd0, rxq[0]});
                  void'(rxq.pop_front());
               end else chk("R8 rand rx empty", v, 16'h0);
            end
            default: begin
               rd(6'd24, v); chk("R7 rand tx count", v, stat_word(1'b1, txq.size()));
               rd(6'd40, v); chk("R7 rand rx count", v, stat_word(1'b1, rxq.size()));
            end
         endcase
         chk("R5 rand irq", {15'd0, irq},
             {15'd0, exp_irq(txq.size(), rxq.size(), 1'b1, 1'b1)});
      end

      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
   end
endmodule